// File: doc/BRIEF.md
# 64-bit Iterative Multiply/Divide Unit with Result-Register Interlock

This block computes full-width integer products and quotients of two 64-bit operands. A multiply yields a 128-bit product. A divide yields a quotient and a remainder. Each result lands in a pair of architectural result registers, HI and LO. Every command runs for a fixed number of cycles: one iteration per operand bit, then one writeback cycle.

A consumer that wants HI or LO raises a read request. While a command is still running, the unit answers with a stall. The stall lasts until the cycle in which the new values are visible on the outputs. Signed commands first convert the operands to magnitudes, iterate on those magnitudes, and correct the sign of the result at writeback.

Top module: `dmd_unit`

## Requirements
- R1: After reset, `hi_o` and `lo_o` are zero, and `busy_o` and `stall_o` are low.
- R2: Unsigned multiply (`op_i` = 2'b01) places the upper 64 bits of the 128-bit product of `rs_i` and `rt_i` on `hi_o` and the lower 64 bits on `lo_o`.
- R3: Signed multiply (`op_i` = 2'b00) treats both operands as two's complement and returns the 128-bit two's complement product split the same way as in R2.
- R4: Unsigned divide (`op_i` = 2'b11) divides `rs_i` by `rt_i`. It puts the quotient on `lo_o` and the remainder on `hi_o`.
- R5: Signed divide (`op_i` = 2'b10) truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x8000_0000_0000_0000 and remainder 0.
- R6: A divide whose divisor is zero completes in the normal cycle count. It sets `lo_o` to all ones and `hi_o` to the unmodified dividend, in both signed and unsigned mode.
- R7: A start is accepted on a rising edge where `start_i` is high and `busy_o` is low. `busy_o` rises after that edge, stays high for exactly 65 cycles, and falls on the edge that writes the result.
- R8: `stall_o` is high in every cycle where `rd_req_i` is high and a command is in flight. It is low once the result is visible.
- R9: A start raised while `busy_o` is high is ignored. The running command's result and latency are unchanged.
- R10: `hi_o` and `lo_o` keep their previous values for the whole time a command is in flight. They change only on the edge where `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 2 | Bit 1: divide (1) or multiply (0). Bit 0: unsigned (1) or signed (0) |
| rs_i | input | 64 | Multiplicand, or dividend |
| rt_i | input | 64 | Multiplier, or divisor |
| rd_req_i | input | 1 | Request to read HI or LO |
| stall_o | output | 1 | Read must wait; a command is in flight |
| busy_o | output | 1 | Command in flight |
| hi_o | output | 64 | HI register: product upper half, or remainder |
| lo_o | output | 64 | LO register: product lower half, or quotient |

## Verification
A wrong iteration count or a stuck phase flag shows up at once as a latency other than 65 cycles, or as a `busy_o` that never falls. A datapath slip of one bit shows up as a product or quotient off by a factor of two at the first writeback. Sign-correction faults only appear for mixed-sign operands, so the operand table pairs every sign combination with each mode, plus the most negative value and a zero divisor. Early writes or a leaking start are caught mid-command: HI/LO are compared against the previous result, and a second start is injected while the unit is busy.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } dmd_op_e;
endpackage

// File: rtl/dmd_abs.sv
module dmd_abs #(
    parameter int W = 64
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = signed_i & val_i[W-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/dmd_step.sv
module dmd_step #(
    parameter int W = 64
) (
    input  logic           is_div_i,
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   opnd_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] sum;
    logic [W:0] part;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        // shift-add: conditional add into upper half, then shift right
        sum  = {1'b0, acc_i[2*W-1:W]} + (acc_i[0] ? {1'b0, opnd_i} : '0);
        // restoring shift-subtract: bring in next dividend bit
        part = {acc_i[2*W-1:W], acc_i[W-1]};
        fits = (part >= {1'b0, opnd_i});
        diff = fits ? (part - {1'b0, opnd_i}) : part;
        if (is_div_i) begin
            acc_o = {diff[W-1:0], acc_i[W-2:0], fits};
        end else begin
            acc_o = {sum, acc_i[W-1:1]};
        end
    end
endmodule

// File: rtl/dmd_unit.sv
module dmd_unit
    import dmd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] rs_i,
    input  logic [W-1:0] rt_i,
    input  logic         rd_req_i,
    output logic         stall_o,
    output logic         busy_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int CW    = $clog2(W);
    localparam int LAT   = W + 1;
    localparam int BCW   = $clog2(LAT + 2);

    typedef struct packed {
        logic           busy;
        logic           fix;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           dz;
        logic           neg_q;
        logic           neg_r;
        logic [2*W-1:0] acc;
        logic [W-1:0]   opnd;
        logic [W-1:0]   dvd;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
    } st_t;

    st_t s_d, s_q;

    logic [W-1:0]   src   [2];
    logic [W-1:0]   mag   [2];
    logic           neg   [2];
    logic [2*W-1:0] acc_nx;
    logic           accept;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;

    assign src[0] = rs_i;
    assign src[1] = rt_i;

    for (genvar g = 0; g < 2; g++) begin : g_abs
        dmd_abs #(.W(W)) u_abs (
            .val_i   (src[g]),
            .signed_i(~op_i[0]),
            .mag_o   (mag[g]),
            .neg_o   (neg[g])
        );
    end

    dmd_step #(.W(W)) u_step (
        .is_div_i(s_q.is_div),
        .acc_i   (s_q.acc),
        .opnd_i  (s_q.opnd),
        .acc_o   (acc_nx)
    );

    always_comb begin
        s_d    = s_q;
        accept = start_i & ~s_q.busy;
        prod   = s_q.neg_q ? (~s_q.acc + 1'b1) : s_q.acc;
        quo    = s_q.neg_q ? (~s_q.acc[W-1:0] + 1'b1) : s_q.acc[W-1:0];
        rem    = s_q.neg_r ? (~s_q.acc[2*W-1:W] + 1'b1) : s_q.acc[2*W-1:W];
        if (accept) begin
            s_d.busy   = 1'b1;
            s_d.fix    = 1'b0;
            s_d.cnt    = '0;
            s_d.is_div = op_i[1];
            s_d.dz     = op_i[1] & (rt_i == '0);
            s_d.neg_q  = neg[0] ^ neg[1];
            s_d.neg_r  = neg[0];
            s_d.dvd    = rs_i;
            if (op_i[1]) begin
                s_d.acc  = {{W{1'b0}}, mag[0]};
                s_d.opnd = mag[1];
            end else begin
                s_d.acc  = {{W{1'b0}}, mag[1]};
                s_d.opnd = mag[0];
            end
        end else if (s_q.busy && !s_q.fix) begin
            s_d.acc = acc_nx;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(W - 1)) begin
                s_d.fix = 1'b1;
            end
        end else if (s_q.busy) begin
            s_d.busy = 1'b0;
            s_d.fix  = 1'b0;
            if (s_q.dz) begin
                s_d.hi = s_q.dvd;
                s_d.lo = '1;
            end else if (s_q.is_div) begin
                s_d.hi = rem;
                s_d.lo = quo;
            end else begin
                s_d.hi = prod[2*W-1:W];
                s_d.lo = prod[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = s_q.busy;
    assign stall_o = rd_req_i & s_q.busy;
    assign hi_o    = s_q.hi;
    assign lo_o    = s_q.lo;

    // checker state: edges spent busy since the last accepted start
    logic [BCW-1:0] bcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q <= '0;
        end else if (accept) begin
            bcnt_q <= '0;
        end else if (s_q.busy) begin
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (bcnt_q == BCW'(LAT))); // R7

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R9

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o))); // R10

    AST_WRITE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hi_o) || !$stable(lo_o)) |-> $fell(busy_o)); // R10

    AST_NO_STALL_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !stall_o); // R8
endmodule

// File: tb/dmd_unit_bench.sv
module dmd_unit_bench;
    localparam int  W   = 64;
    localparam time CLK = 20ns;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } vec_t;

    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    localparam vec_t VEC [13] = '{
        '{2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'b01, 64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321},
        '{2'b00, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5},
        '{2'b00, MINV, MINV},
        '{2'b00, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFF5},
        '{2'b11, 64'd100, 64'd7},
        '{2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3},
        '{2'b10, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2},
        '{2'b10, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE},
        '{2'b10, MINV, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'b11, 64'd55, 64'd0},
        '{2'b10, 64'hFFFF_FFFF_FFFF_FFF7, 64'd0},
        '{2'b10, 64'hFFFF_FFFF_FFFF_FFE0, 64'hFFFF_FFFF_FFFF_FFF9}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = '0;
    logic [W-1:0] rs_i = '0;
    logic [W-1:0] rt_i = '0;
    logic         rd_req_i = 1'b0;
    logic         stall_o, busy_o;
    logic [W-1:0] hi_o, lo_o;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] prev_hi = '0;
    logic [W-1:0] prev_lo = '0;

    always #(CLK/2) clk = ~clk;

    dmd_unit #(.W(W)) u_dmd_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .rs_i(rs_i), .rt_i(rt_i), .rd_req_i(rd_req_i),
        .stall_o(stall_o), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model(input logic [1:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic signed [127:0] sp;
        logic signed [W-1:0] sa, sb, sq, sr;
        sa = a;
        sb = b;
        case (op)
            2'b01: return {64'b0, a} * {64'b0, b};
            2'b00: begin
                sp = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
                return sp;
            end
            2'b11: begin
                if (b == '0) return {a, {W{1'b1}}};
                return {a % b, a / b};
            end
            default: begin
                if (b == '0) return {a, {W{1'b1}}};
                if (a == MINV && b == '1) return {{W{1'b0}}, MINV};
                sq = sa / sb;
                sr = sa % sb;
                return {sr, sq};
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [W-1:0] b);
        if (op[1] && b == '0) return "R6";
        case (op)
            2'b01:   return "R2";
            2'b00:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit probe_stall, input bit inject_start);
        int n;
        logic [127:0] exp;
        exp = model(op, a, b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; rs_i = a; rt_i = b;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        check("R7 busy after accept", {127'b0, busy_o}, 128'd1);
        while (busy_o && n < 1000) begin
            if (n == 10) begin
                check("R10 hold while busy", {hi_o, lo_o}, {prev_hi, prev_lo});
                if (probe_stall) begin
                    rd_req_i = 1'b1;
                    #1;
                    check("R8 stall while busy", {127'b0, stall_o}, 128'd1);
                end
                if (inject_start) begin
                    start_i = 1'b1; op_i = ~op; rs_i = ~a; rt_i = 64'd3;
                end
            end
            if (n == 11) start_i = 1'b0;
            @(negedge clk);
            n++;
        end
        check("R7 latency", 128'(n), 128'd65);
        if (probe_stall) begin
            check("R8 stall released", {127'b0, stall_o}, 128'd0);
            rd_req_i = 1'b0;
        end
        check(inject_start ? "R9 start ignored" : tag_of(op, b), {hi_o, lo_o}, exp);
        if (inject_start) begin
            @(negedge clk);
            check("R9 no second command", {127'b0, busy_o}, 128'd0);
        end
        prev_hi = hi_o;
        prev_lo = lo_o;
    endtask

    initial begin
        #(CLK * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset hi/lo", {hi_o, lo_o}, 128'd0);
        check("R1 reset busy/stall", {126'b0, busy_o, stall_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b1;
        #1;
        check("R8 no stall when idle", {127'b0, stall_o}, 128'd0);
        rd_req_i = 1'b0;

        for (int i = 0; i < 13; i++) begin
            run_op(VEC[i].op, VEC[i].a, VEC[i].b, (i == 2) || (i == 10), 1'b0);
        end

        run_op(2'b11, 64'd1000, 64'd9, 1'b1, 1'b1);
        run_op(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule